// File: doc/BRIEF.md
# Monitor Sense Line Sequencer

This block identifies an attached display by probing three open sense lines, called A, B and C. On a start pulse it pulls all three lines high for a short settle time. It then lets them float and reads them. Next it pulls A low, then B low, then C low. In each of those steps it reads the two lines it leaves free. The readings go into an 11-bit identification code. The host sees a busy flag, a one-cycle done pulse and the finished code. Turning the code into a display mode is left to other logic.

Toward the pads the block has a level and a release flag for each line. A release flag of 1 means the line is not driven. It also has one sampled input per line. In every 3-bit pad vector, bit 2 is line A, bit 1 is line B and bit 0 is line C. The two settle times are parameters, so short values can be used in simulation.

Top module: `mon_sense_seq`

## Requirements
- R1: After reset, and whenever the block is idle, busy_o is 0, all three release flags are 1 (line_rel_o = 3'b111) and all levels are 1. After reset, sense_o is 0 and done_o is 0.
- R2: A start pulse taken while idle begins the drive-high step in the next cycle. In this step line_lvl_o = 3'b111 and line_rel_o = 3'b000, and it lasts SHORT_WAIT cycles.
- R3: The float step comes next. All lines are released (line_rel_o = 3'b111) for LONG_WAIT cycles. On its last cycle the readings of A, B and C are stored in code bits 10, 9 and 8.
- R4: The A-low step drives only A, to 0 (line_lvl_o = 3'b011, line_rel_o = 3'b011), for LONG_WAIT cycles. At its end, B is stored in bit 5 and C in bit 4.
- R5: The B-low step drives only B low (line_lvl_o = 3'b101, line_rel_o = 3'b101) for LONG_WAIT cycles. At its end, A is stored in bit 3 and C in bit 2. No more than one line is ever driven low at a time.
- R6: The C-low step drives only C low (line_lvl_o = 3'b110, line_rel_o = 3'b110) for LONG_WAIT cycles. At its end, A is stored in bit 1 and B in bit 0.
- R7: Bits 7 and 6 of sense_o are always 0.
- R8: The result is published exactly SHORT_WAIT + 4*LONG_WAIT cycles after the start edge. In that cycle done_o is 1 for exactly one cycle, busy_o is 0, all lines are released and sense_o holds the new code.
- R9: A start pulse that arrives while busy_o is 1 is ignored. The running sequence keeps its timing and its result.
- R10: sense_o changes only in the cycle where done_o is 1. It keeps the previous code for the whole of a following run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start pulse for a probe sequence |
| line_in_i | input | 3 | Sampled line states {A,B,C} |
| line_lvl_o | output | 3 | Driven level per line {A,B,C} |
| line_rel_o | output | 3 | Release flag per line {A,B,C}, 1 = not driven |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when sense_o is updated |
| sense_o | output | 11 | Packed identification code |

## Verification
The bench models the display side with a pad model. Each free line reads a configurable pull value unless a configured short ties it to a line that is being driven low. Six monitor configurations are used:
- All-high and all-low pulls show whether the float readings land in bits 10:8 and whether the zero field stays zero.
- Each single short (A-B, A-C, B-C) gives a pattern that is unique to it. Swapping any two step fields, or swapping the two lines within one field, changes the code.
- Shorting all lines together checks that each driven-low step clears exactly its own field.

Pad levels are checked at the boundary cycles of every step. A second start during a run, a run that follows a finished run, and a reset in mid-run cover R9, R10 and R1.

// File: rtl/mss_pkg.sv
package mss_pkg;

  localparam int LINES  = 3;
  localparam int CODE_W = 11;

  // Pad vector bit positions
  localparam int IDX_A = 2;
  localparam int IDX_B = 1;
  localparam int IDX_C = 0;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_HIGH  = 3'd1,
    PH_FLOAT = 3'd2,
    PH_A_LO  = 3'd3,
    PH_B_LO  = 3'd4,
    PH_C_LO  = 3'd5
  } phase_e;

  // Step in which a given line is pulled low
  function automatic phase_e low_phase(input int idx);
    case (idx)
      IDX_A:   return PH_A_LO;
      IDX_B:   return PH_B_LO;
      default: return PH_C_LO;
    endcase
  endfunction

endpackage

// File: rtl/mss_timer.sv
module mss_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/mss_pad_drive.sv
module mss_pad_drive
  import mss_pkg::*;
(
  input  phase_e           phase_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rel_o
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic pull_low;
    assign pull_low = (phase_i == low_phase(i));
    assign lvl_o[i] = !pull_low;
    // Driven during the high step, or when this line is the one pulled low
    assign rel_o[i] = !((phase_i == PH_HIGH) || pull_low);
  end

endmodule

// File: rtl/mss_pack.sv
module mss_pack
  import mss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              finish_i,
  input  phase_e            phase_i,
  input  logic [LINES-1:0]  line_i,
  output logic [CODE_W-1:0] code_o
);

  logic [CODE_W-1:0] shadow_q;
  logic [CODE_W-1:0] shadow_d;
  logic              shadow_en;
  logic [CODE_W-1:0] code_q;

  always_comb begin
    shadow_d = clear_i ? '0 : shadow_q;
    if (sample_i) begin
      case (phase_i)
        PH_FLOAT: shadow_d[10:8] = {line_i[IDX_A], line_i[IDX_B], line_i[IDX_C]};
        PH_A_LO:  shadow_d[5:4]  = {line_i[IDX_B], line_i[IDX_C]};
        PH_B_LO:  shadow_d[3:2]  = {line_i[IDX_A], line_i[IDX_C]};
        PH_C_LO:  shadow_d[1:0]  = {line_i[IDX_A], line_i[IDX_B]};
        default:  ;
      endcase
    end
    shadow_d[7:6] = 2'b00;
    shadow_en     = clear_i || sample_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow_q <= '0;
    else if (shadow_en) shadow_q <= shadow_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        code_q <= '0;
    else if (finish_i) code_q <= shadow_d;
  end

  assign code_o = code_q;

endmodule

// File: rtl/mon_sense_seq.sv
module mon_sense_seq
  import mss_pkg::*;
#(
  parameter int SHORT_WAIT = 200,
  parameter int LONG_WAIT  = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LINES-1:0]  line_in_i,
  output logic [LINES-1:0]  line_lvl_o,
  output logic [LINES-1:0]  line_rel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CODE_W-1:0] sense_o
);

  localparam int MAX_WAIT = (SHORT_WAIT > LONG_WAIT) ? SHORT_WAIT : LONG_WAIT;
  localparam int CNT_W    = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1;
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_WAIT - 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_WAIT - 1);

  phase_e           ph_q, ph_d;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             expired;
  logic             sample;
  logic             finish;
  logic             accept;
  logic             done_q;

  always_comb begin
    ph_d   = ph_q;
    ld     = 1'b0;
    ld_val = LONG_LD;
    sample = 1'b0;
    finish = 1'b0;
    accept = 1'b0;
    case (ph_q)
      PH_IDLE: if (start_i) begin
        accept = 1'b1;
        ph_d   = PH_HIGH;
        ld     = 1'b1;
        ld_val = SHORT_LD;
      end
      PH_HIGH: if (expired) begin
        ph_d = PH_FLOAT;
        ld   = 1'b1;
      end
      PH_FLOAT: if (expired) begin
        sample = 1'b1;
        ph_d   = PH_A_LO;
        ld     = 1'b1;
      end
      PH_A_LO: if (expired) begin
        sample = 1'b1;
        ph_d   = PH_B_LO;
        ld     = 1'b1;
      end
      PH_B_LO: if (expired) begin
        sample = 1'b1;
        ph_d   = PH_C_LO;
        ld     = 1'b1;
      end
      PH_C_LO: if (expired) begin
        sample = 1'b1;
        finish = 1'b1;
        ph_d   = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= finish;
  end

  mss_timer #(.W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (ld),
    .val_i     (ld_val),
    .expired_o (expired)
  );

  mss_pad_drive u_pads (
    .phase_i (ph_q),
    .lvl_o   (line_lvl_o),
    .rel_o   (line_rel_o)
  );

  mss_pack u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (accept),
    .sample_i (sample),
    .finish_i (finish),
    .phase_i  (ph_q),
    .line_i   (line_in_i),
    .code_o   (sense_o)
  );

  assign busy_o = (ph_q != PH_IDLE);
  assign done_o = done_q;

endmodule

// File: rtl/mss_checker.sv
module mss_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy_o,
  input logic        done_o,
  input logic [10:0] sense_o,
  input logic [2:0]  line_lvl_o,
  input logic [2:0]  line_rel_o
);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (line_rel_o == 3'b111));

  assert_high_on_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (line_lvl_o == 3'b111 && line_rel_o == 3'b000));

  assert_single_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~line_lvl_o & ~line_rel_o) <= 1);

  assert_zero_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sense_o[7:6] == 2'b00);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_code_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(sense_o));

endmodule

bind mon_sense_seq mss_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .sense_o    (sense_o),
  .line_lvl_o (line_lvl_o),
  .line_rel_o (line_rel_o)
);

// File: tb/mon_sense_seq_tb.sv
module mon_sense_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SH = 4;
  localparam int LG = 10;
  localparam int TOTAL = SH + 4 * LG;
  localparam int NVEC = 6;

  // {pull A,B,C, short AB, short AC, short BC, expected code}
  localparam logic [16:0] VEC [NVEC] = '{
    {6'b111_000, 11'h73F},
    {6'b111_100, 11'h717},
    {6'b000_000, 11'h000},
    {6'b101_001, 11'h51A},
    {6'b011_010, 11'h325},
    {6'b110_111, 11'h600}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  line_in_i;
  logic [2:0]  line_lvl_o, line_rel_o;
  logic        busy_o, done_o;
  logic [10:0] sense_o;

  logic [2:0] pull;
  logic       s_ab, s_ac, s_bc;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mon_sense_seq #(.SHORT_WAIT(SH), .LONG_WAIT(LG)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .line_in_i  (line_in_i),
    .line_lvl_o (line_lvl_o),
    .line_rel_o (line_rel_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .sense_o    (sense_o)
  );

  // Display-side model: driven line reads its level; a free line reads 0 if
  // shorted to a line driven low, else its pull value.
  always_comb begin
    logic dA, dB, dC, lA, lB, lC;
    dA = !line_rel_o[2]; dB = !line_rel_o[1]; dC = !line_rel_o[0];
    lA = dA && !line_lvl_o[2]; lB = dB && !line_lvl_o[1]; lC = dC && !line_lvl_o[0];
    line_in_i[2] = dA ? line_lvl_o[2] : (((s_ab && lB) || (s_ac && lC)) ? 1'b0 : pull[2]);
    line_in_i[1] = dB ? line_lvl_o[1] : (((s_ab && lA) || (s_bc && lC)) ? 1'b0 : pull[1]);
    line_in_i[0] = dC ? line_lvl_o[0] : (((s_ac && lA) || (s_bc && lB)) ? 1'b0 : pull[0]);
  end

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Pulse start, then step through the run checking pads at step boundaries.
  // extra_at: cycle index at which a second start is pulsed (-1 = none).
  task automatic run(input logic [10:0] exp_code, input int extra_at, input logic [10:0] prev_code);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int k = 0; k <= TOTAL + 1; k++) begin
      if (k > 0) @(negedge clk);
      start_i = (k == extra_at);
      if (k == 0 || k == SH - 1)
        chk(line_lvl_o == 3'b111 && line_rel_o == 3'b000, "R2", {line_lvl_o, line_rel_o}, 6'b111000);
      if (k == SH || k == SH + LG - 1)
        chk(line_rel_o == 3'b111, "R3", line_rel_o, 3'b111);
      if (k == SH + LG || k == SH + 2*LG - 1)
        chk(line_lvl_o == 3'b011 && line_rel_o == 3'b011, "R4", {line_lvl_o, line_rel_o}, 6'b011011);
      if (k == SH + 2*LG || k == SH + 3*LG - 1)
        chk(line_lvl_o == 3'b101 && line_rel_o == 3'b101, "R5", {line_lvl_o, line_rel_o}, 6'b101101);
      if (k == SH + 3*LG || k == TOTAL - 1) begin
        chk(line_lvl_o == 3'b110 && line_rel_o == 3'b110, "R6", {line_lvl_o, line_rel_o}, 6'b110110);
        chk(busy_o && !done_o, "R8 busy before end", {busy_o, done_o}, 2'b10);
      end
      if (k == SH + LG + 3)
        chk(sense_o == prev_code, "R10 hold during run", sense_o, prev_code);
      if (k == TOTAL) begin
        chk(done_o && !busy_o && line_rel_o == 3'b111, "R8 done", {done_o, busy_o, line_rel_o}, 5'b10111);
        chk(sense_o == exp_code, "R3 R4 R5 R6 code", sense_o, exp_code);
        chk(sense_o[7:6] == 2'b00, "R7", sense_o[7:6], 2'b00);
      end
      if (k == TOTAL + 1)
        chk(!done_o && sense_o == exp_code, "R8 single pulse", {done_o, sense_o}, {1'b0, exp_code});
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [10:0] prev;
    rst_n = 1'b0; start_i = 1'b0;
    pull = 3'b111; {s_ab, s_ac, s_bc} = 3'b000;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && sense_o == 0 && line_rel_o == 3'b111 && line_lvl_o == 3'b111,
        "R1 reset", {busy_o, done_o, sense_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && line_rel_o == 3'b111, "R1 idle", {busy_o, line_rel_o}, 4'b0111);

    prev = 11'h000;
    for (int v = 0; v < NVEC; v++) begin
      {pull, s_ab, s_ac, s_bc} = VEC[v][16:11];
      run(VEC[v][10:0], -1, prev);
      prev = VEC[v][10:0];
      repeat (2) @(negedge clk);
    end

    // R9: second start mid-run changes neither timing nor result
    {pull, s_ab, s_ac, s_bc} = VEC[3][16:11];
    run(VEC[3][10:0], SH + LG + 2, prev);
    prev = VEC[3][10:0];

    // R1: reset mid-run returns to idle with code cleared
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (SH + LG) @(negedge clk);
    chk(busy_o, "R1 pre-reset busy", busy_o, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy_o && line_rel_o == 3'b111 && sense_o == 0, "R1 mid-run reset",
        {busy_o, line_rel_o, sense_o}, 0);
    rst_n = 1'b1;
    repeat (TOTAL + 4) @(negedge clk);
    chk(!busy_o && !done_o && sense_o == 0, "R1 stays idle", {busy_o, done_o, sense_o}, 0);

    summary();
  end

endmodule